// File: doc/BRIEF.md
# Windowed Service Watchdog with Two-Stage Fail Escalation

This block supervises an external microcontroller that proves it is alive by writing a single trigger bit through a register interface. After reset, after a failure, after a regulator undervoltage event or after a wake from deep standby the watchdog sits in a long open window; writing a 1 ends that window and starts windowed service. From then on each cycle must be closed by writing the opposite of the previously written value, neither too early (before the closed part of the window has elapsed) nor too late (after the window end).

Every failure produces a reset pulse for the microcontroller and asserts a gate-driver fail-safe disable that is held until the next correct service. Consecutive failures are counted: at the eighth the block requests that the supply regulator be switched off for a timed interval, and after seven further consecutive failures it requests permanent regulator shutdown with entry to battery standby, held until a wake event. The watchdog is inactive in flash mode, and a disable bit written while in flash mode keeps it inactive until the next power-on reset. All window and pulse lengths are parameters in clock cycles.

Top module: `wdg_escalate`

## Requirements
- R1: While rst_n is low and in the first sample after its release, rst_pulse, gate_fs, reg_off and force_stby are all 0, and the watchdog starts in the long open window with a cleared cycle counter.
- R2: In the long open window a write with trig_val=1 ends the window and starts windowed service with 1 as the last written value; a write with trig_val=0 has no effect; if no 1 is written within LONG_CYC cycles the window expires as a failure on the LONG_CYC-th clock edge.
- R3: In windowed service a write whose value differs from the last written value is a correct service when at least EARLY_CYC cycles of the window have elapsed and a failure when fewer have; a correct service restarts the window at once; without a correct service the window fails on its WIN_CYC-th clock edge.
- R4: In windowed service a write of the same value as the last written value is ignored: it is neither a service nor a failure.
- R5: A failure raises rst_pulse on the same clock edge for exactly PULSE_CYC cycles, sets gate_fs until the next correct service, and restarts the long open window.
- R6: The FIRST_FAILS-th consecutive failure raises reg_off for exactly REGOFF_CYC cycles; while reg_off is high the watchdog is suspended and produces no failure, and it restarts in the long open window afterwards.
- R7: Failure number FIRST_FAILS+SECOND_FAILS in a row sets force_stby, which stays high and suspends the watchdog until wake_evt.
- R8: While flash_mode is 1 the watchdog produces no failure; if wd_dis is 1 in a cycle where flash_mode is 1, the watchdog stays inactive after flash mode is left until rst_n is asserted; wd_dis outside flash mode has no effect.
- R9: vdd_uv or wake_evt restarts the long open window without a failure; wake_evt also clears force_stby, reg_off and the consecutive-failure count.
- R10: A correct service (including the 1 that ends the long window) clears the consecutive-failure count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| trig_wr | input | 1 | Trigger-bit write strobe |
| trig_val | input | 1 | Value written to the trigger bit |
| flash_mode | input | 1 | Flash-programming mode indication |
| wd_dis | input | 1 | Watchdog disable bit (latched only in flash mode) |
| vdd_uv | input | 1 | Regulator undervoltage event |
| wake_evt | input | 1 | Wake event from battery standby |
| rst_pulse | output | 1 | Reset pulse to the microcontroller |
| gate_fs | output | 1 | Gate-driver fail-safe disable |
| reg_off | output | 1 | Timed regulator-off request |
| force_stby | output | 1 | Permanent regulator shutdown / battery standby request |

## Verification
The hardest state to reach is the second escalation stage: fifteen failures in a row, with the timed regulator-off interval between the eighth and ninth, so that the exact length of the suspension and the restart of the long window after it both matter. The bench reaches it by letting the long window expire repeatedly from reset, checking the reset pulse at each twenty-cycle boundary, then waits past the standby request and issues a wake to prove the count was cleared. The early/late boundary of windowed service is swept at every offset inside the window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic {
      PH_LONG = 1'b0,
      PH_WIN  = 1'b1
   } wdg_phase_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wdg_stretch.sv
module wdg_stretch #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic clr,
   output logic active
);
   localparam int LW = $clog2(LEN + 1);
   localparam logic [LW-1:0] LOAD = LW'(LEN);

   logic [LW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (start)          cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);
endmodule

// File: rtl/wdg_window_timer.sv
module wdg_window_timer
   import wdg_pkg::*;
#(
   parameter int LONG_CYC  = 20,
   parameter int EARLY_CYC = 4,
   parameter int WIN_CYC   = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_wr,
   input  logic trig_val,
   input  logic flash_mode,
   input  logic wd_dis,
   input  logic hold,
   input  logic restart,
   output logic svc_ok,
   output logic fail
);
   localparam int MAXC = max2(LONG_CYC, WIN_CYC);
   localparam int CW   = $clog2(MAXC);
   localparam logic [CW-1:0] LONG_LAST = CW'(LONG_CYC - 1);
   localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_CYC - 1);
   localparam logic [CW-1:0] EARLY_V   = CW'(EARLY_CYC);

   wdg_phase_e    ph_q, ph_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          last_q, last_d;
   logic          lock_q;
   logic          active;

   assign active = !flash_mode && !lock_q && !hold && !restart;

   always_comb begin
      ph_d   = ph_q;
      cnt_d  = cnt_q;
      last_d = last_q;
      svc_ok = 1'b0;
      fail   = 1'b0;
      if (!active) begin
         ph_d  = PH_LONG;
         cnt_d = '0;
      end else begin
         unique case (ph_q)
            PH_LONG: begin
               if (trig_wr && trig_val)     svc_ok = 1'b1;
               else if (cnt_q == LONG_LAST) fail   = 1'b1;
               else                         cnt_d  = cnt_q + 1'b1;
            end
            PH_WIN: begin
               if (trig_wr && (trig_val != last_q)) begin
                  if (cnt_q < EARLY_V) fail   = 1'b1;
                  else                 svc_ok = 1'b1;
               end else if (cnt_q == WIN_LAST) begin
                  fail = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            default: ph_d = PH_LONG;
         endcase
         if (svc_ok) begin
            ph_d   = PH_WIN;
            cnt_d  = '0;
            last_d = trig_val;
         end else if (fail) begin
            ph_d  = PH_LONG;
            cnt_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_LONG;
         cnt_q  <= '0;
         last_q <= 1'b0;
         lock_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         last_q <= last_d;
         lock_q <= lock_q | (flash_mode & wd_dis);
      end
   end
endmodule

// File: rtl/wdg_escalator.sv
module wdg_escalator #(
   parameter int FIRST_FAILS  = 8,
   parameter int SECOND_FAILS = 7,
   parameter int REGOFF_CYC   = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fail,
   input  logic svc_ok,
   input  logic wake,
   output logic gate_fs,
   output logic reg_off,
   output logic stby,
   output logic hold
);
   localparam int TOTAL = FIRST_FAILS + SECOND_FAILS;
   localparam int FW    = $clog2(TOTAL + 1);
   localparam logic [FW-1:0] FIRST_HIT = FW'(FIRST_FAILS - 1);
   localparam logic [FW-1:0] TOTAL_V   = FW'(TOTAL);

   logic [FW-1:0] fcnt_q;
   logic          gate_q;
   logic          stage1_hit;

   assign stage1_hit = fail && (fcnt_q == FIRST_HIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q <= '0;
         gate_q <= 1'b0;
      end else begin
         if (wake || svc_ok)                   fcnt_q <= '0;
         else if (fail && fcnt_q != TOTAL_V)   fcnt_q <= fcnt_q + 1'b1;
         if (fail)        gate_q <= 1'b1;
         else if (svc_ok) gate_q <= 1'b0;
      end
   end

   wdg_stretch #(.LEN(REGOFF_CYC)) regoff_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (stage1_hit),
      .clr    (wake),
      .active (reg_off)
   );

   generate
      if (SECOND_FAILS > 0) begin : g_stage2
         localparam logic [FW-1:0] TOTAL_HIT = FW'(TOTAL - 1);
         logic stby_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   stby_q <= 1'b0;
            else if (wake)                                stby_q <= 1'b0;
            else if (fail && fcnt_q == TOTAL_HIT)         stby_q <= 1'b1;
         end
         assign stby = stby_q;
      end else begin : g_no_stage2
         assign stby = 1'b0;
      end
   endgenerate

   assign gate_fs = gate_q;
   assign hold    = reg_off | stby;
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate #(
   parameter int LONG_CYC     = 3_250_000,
   parameter int EARLY_CYC    = 250_000,
   parameter int WIN_CYC      = 1_000_000,
   parameter int PULSE_CYC    = 50_000,
   parameter int REGOFF_CYC   = 10_000_000,
   parameter int FIRST_FAILS  = 8,
   parameter int SECOND_FAILS = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_wr,
   input  logic trig_val,
   input  logic flash_mode,
   input  logic wd_dis,
   input  logic vdd_uv,
   input  logic wake_evt,
   output logic rst_pulse,
   output logic gate_fs,
   output logic reg_off,
   output logic force_stby
);
   generate
      if (LONG_CYC < 2)          begin : g_chk_long  $error("LONG_CYC must be at least 2");          end
      if (EARLY_CYC < 1)         begin : g_chk_early $error("EARLY_CYC must be at least 1");         end
      if (WIN_CYC <= EARLY_CYC)  begin : g_chk_win   $error("WIN_CYC must exceed EARLY_CYC");        end
      if (PULSE_CYC < 1)         begin : g_chk_pulse $error("PULSE_CYC must be at least 1");         end
      if (REGOFF_CYC < 1)        begin : g_chk_roff  $error("REGOFF_CYC must be at least 1");        end
      if (FIRST_FAILS < 1)       begin : g_chk_first $error("FIRST_FAILS must be at least 1");       end
      if (SECOND_FAILS < 0)      begin : g_chk_sec   $error("SECOND_FAILS must not be negative");    end
   endgenerate

   logic fail_w;
   logic ok_w;
   logic hold_w;
   logic restart_w;

   assign restart_w = vdd_uv | wake_evt;

   wdg_window_timer #(
      .LONG_CYC  (LONG_CYC),
      .EARLY_CYC (EARLY_CYC),
      .WIN_CYC   (WIN_CYC)
   ) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_wr    (trig_wr),
      .trig_val   (trig_val),
      .flash_mode (flash_mode),
      .wd_dis     (wd_dis),
      .hold       (hold_w),
      .restart    (restart_w),
      .svc_ok     (ok_w),
      .fail       (fail_w)
   );

   wdg_escalator #(
      .FIRST_FAILS  (FIRST_FAILS),
      .SECOND_FAILS (SECOND_FAILS),
      .REGOFF_CYC   (REGOFF_CYC)
   ) esc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .fail    (fail_w),
      .svc_ok  (ok_w),
      .wake    (wake_evt),
      .gate_fs (gate_fs),
      .reg_off (reg_off),
      .stby    (force_stby),
      .hold    (hold_w)
   );

   wdg_stretch #(.LEN(PULSE_CYC)) pulse_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (fail_w),
      .clr    (1'b0),
      .active (rst_pulse)
   );
endmodule

// File: rtl/wdg_escalate_chk.sv
module wdg_escalate_chk (
   input logic clk,
   input logic rst_n,
   input logic flash_mode,
   input logic vdd_uv,
   input logic wake_evt,
   input logic fail_w,
   input logic ok_w,
   input logic rst_pulse,
   input logic gate_fs,
   input logic reg_off,
   input logic force_stby
);
   AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fail_w |=> (rst_pulse && gate_fs)); // R5
   AST_OK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_w && !fail_w) |=> !gate_fs); // R10
   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      reg_off |-> !fail_w); // R6
   AST_STBY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (force_stby && !wake_evt) |=> force_stby); // R7
   AST_FLASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      flash_mode |-> !fail_w); // R8
   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (vdd_uv || wake_evt) |-> !fail_w); // R9
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fail_w, ok_w})); // R3
endmodule

bind wdg_escalate wdg_escalate_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .flash_mode (flash_mode),
   .vdd_uv     (vdd_uv),
   .wake_evt   (wake_evt),
   .fail_w     (fail_w),
   .ok_w       (ok_w),
   .rst_pulse  (rst_pulse),
   .gate_fs    (gate_fs),
   .reg_off    (reg_off),
   .force_stby (force_stby)
);

// File: tb/wdg_escalate_tb_top.sv
module wdg_escalate_tb_top;
   localparam int LONG_C  = 20;
   localparam int EARLY_C = 4;
   localparam int WIN_C   = 10;
   localparam int PULSE_C = 3;
   localparam int ROFF_C  = 12;
   localparam int FIRST_C = 8;
   localparam int SEC_C   = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig_wr = 1'b0, trig_val = 1'b0, flash_mode = 1'b0, wd_dis = 1'b0;
   logic vdd_uv = 1'b0, wake_evt = 1'b0;
   logic rst_pulse, gate_fs, reg_off, force_stby;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10ns clk = ~clk;

   wdg_escalate #(
      .LONG_CYC (LONG_C), .EARLY_CYC (EARLY_C), .WIN_CYC (WIN_C),
      .PULSE_CYC (PULSE_C), .REGOFF_CYC (ROFF_C),
      .FIRST_FAILS (FIRST_C), .SECOND_FAILS (SEC_C)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .trig_wr (trig_wr), .trig_val (trig_val),
      .flash_mode (flash_mode), .wd_dis (wd_dis), .vdd_uv (vdd_uv),
      .wake_evt (wake_evt), .rst_pulse (rst_pulse), .gate_fs (gate_fs),
      .reg_off (reg_off), .force_stby (force_stby)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_count(input int n, output int hi);
      hi = 0;
      repeat (n) begin
         @(negedge clk);
         if (rst_pulse) hi++;
      end
   endtask

   task automatic wr(input logic v);
      trig_wr = 1'b1; trig_val = v;
      idle(1);
      trig_wr = 1'b0;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got 0 expected 1 (run finished)");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int hi;
      idle(1);
      // R1 reset state
      chk("R1 rst_pulse in reset", rst_pulse, 0);
      chk("R1 gate_fs in reset", gate_fs, 0);
      chk("R1 reg_off in reset", reg_off, 0);
      chk("R1 force_stby in reset", force_stby, 0);
      do_reset();
      idle(1);
      chk("R1 outputs after release", {rst_pulse, gate_fs, reg_off, force_stby}, 0);

      // R2 long window: write 0 ignored, expiry at edge LONG_C
      do_reset();
      wr(1'b0);
      idle(LONG_C - 2);
      chk("R2 no expiry before LONG_CYC", rst_pulse, 0);
      idle(1);
      chk("R2 expiry at LONG_CYC", rst_pulse, 1);
      chk("R5 gate_fs on failure", gate_fs, 1);
      idle(PULSE_C - 1);
      chk("R5 pulse still high at PULSE_CYC-1", rst_pulse, 1);
      idle(1);
      chk("R5 pulse ends after PULSE_CYC", rst_pulse, 0);
      chk("R5 gate_fs held", gate_fs, 1);
      wr(1'b1);
      chk("R5 R2 gate_fs released by service", gate_fs, 0);

      // R3 sweep of the service offset inside the window
      for (int d = 0; d < WIN_C; d++) begin
         do_reset();
         wr(1'b1);
         idle(d);
         wr(1'b0);
         chk($sformatf("R3 toggle at offset %0d pulse", d), rst_pulse, (d < EARLY_C) ? 1 : 0);
         chk($sformatf("R3 toggle at offset %0d gate_fs", d), gate_fs, (d < EARLY_C) ? 1 : 0);
      end

      // R3 window timeout
      do_reset();
      wr(1'b1);
      idle(WIN_C - 1);
      chk("R3 no timeout before WIN_CYC", rst_pulse, 0);
      idle(1);
      chk("R3 timeout at WIN_CYC", rst_pulse, 1);

      // R4 same value ignored even in the early part
      do_reset();
      wr(1'b1);
      idle(1);
      wr(1'b1);
      chk("R4 early same-value write ignored", rst_pulse, 0);
      idle(EARLY_C - 2);
      wr(1'b0);
      chk("R4 later toggle accepted", rst_pulse, 0);
      wr(1'b0);
      idle(WIN_C - 3);
      chk("R4 repeat did not restart window", rst_pulse, 0);

      // R6 R7 escalation
      do_reset();
      for (int i = 1; i <= FIRST_C; i++) begin
         idle(LONG_C);
         chk($sformatf("R5 failure %0d pulse", i), rst_pulse, 1);
         chk($sformatf("R6 failure %0d reg_off", i), reg_off, (i == FIRST_C) ? 1 : 0);
      end
      idle(ROFF_C - 1);
      chk("R6 reg_off held REGOFF_CYC-1", reg_off, 1);
      idle(1);
      chk("R6 reg_off ends after REGOFF_CYC", reg_off, 0);
      for (int i = FIRST_C + 1; i <= FIRST_C + SEC_C; i++) begin
         idle(LONG_C);
         chk($sformatf("R6 failure %0d pulse", i), rst_pulse, 1);
         chk($sformatf("R6 failure %0d no reg_off", i), reg_off, 0);
         chk($sformatf("R7 failure %0d force_stby", i), force_stby, (i == FIRST_C + SEC_C) ? 1 : 0);
      end
      idle(PULSE_C + 2);
      idle_count(60, hi);
      chk("R7 suspended in standby", hi, 0);
      chk("R7 standby held", force_stby, 1);
      wake_evt = 1'b1;
      idle(1);
      wake_evt = 1'b0;
      chk("R9 wake clears force_stby", force_stby, 0);
      idle(LONG_C - 1);
      chk("R9 long window after wake", rst_pulse, 0);
      idle(1);
      chk("R9 failure after wake", rst_pulse, 1);
      chk("R9 count cleared by wake", reg_off, 0);

      // R10 service clears the failure count
      do_reset();
      idle(LONG_C * (FIRST_C - 1));
      wr(1'b1);
      idle(WIN_C);
      chk("R10 timeout pulse", rst_pulse, 1);
      chk("R10 count cleared, no reg_off", reg_off, 0);

      // R9 undervoltage restarts long window
      do_reset();
      wr(1'b1);
      idle(5);
      vdd_uv = 1'b1;
      idle(1);
      vdd_uv = 1'b0;
      chk("R9 no failure from vdd_uv", rst_pulse, 0);
      idle(LONG_C - 1);
      chk("R9 long window after vdd_uv", rst_pulse, 0);
      idle(1);
      chk("R9 expiry after vdd_uv", rst_pulse, 1);

      // R8 flash mode and disable lock
      do_reset();
      flash_mode = 1'b1;
      idle_count(100, hi);
      chk("R8 no failure in flash", hi, 0);
      wd_dis = 1'b1;
      idle(1);
      wd_dis = 1'b0;
      flash_mode = 1'b0;
      idle_count(100, hi);
      chk("R8 lock after flash", hi, 0);
      do_reset();
      idle(LONG_C);
      chk("R8 lock cleared by reset", rst_pulse, 1);
      do_reset();
      wd_dis = 1'b1;
      idle(LONG_C);
      chk("R8 wd_dis ignored outside flash", rst_pulse, 1);
      wd_dis = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule